// File: doc/BRIEF.md
# Way Contraction Flush Controller

This block takes one core's access right to one way of a partitioned shared last-level cache away, safely. Every modified line that way holds must reach main memory before the right is withdrawn. While a contraction runs, the way is marked as draining. Any core's ordinary lookup that lands on an unfinished set of that way does the flush work for that set. A dirty line is sent out through a request/acknowledge writeback port, and a clean or invalid line is simply recorded as finished.

A per-set record holds one bit per set and shows which sets are finished. A background walker visits the sets that no lookup happens to reach. It probes the line state of the set it points at and flushes or records it, always giving way to a lookup-triggered flush. When every set is recorded and no writeback is outstanding, the controller does four things on one clock edge: it drops the core's permission bit for the way, drops the draining bit, clears the record and pulses a completion output. Only one contraction runs at a time, and requests made while one is running are refused.

The permission and draining bits are kept here as flat output maps. The cache's lookup logic uses them to decide which ways a core may read.

Top module: `wayshrink_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `wb_req` are 0, every bit of `perm_map` is 1 and every bit of `flush_map` is 0.
- R2: A request (`start_valid`) seen while `busy` is 0 is accepted. From the next cycle `busy` is 1 and `flush_map[start_way]` is 1. A request seen while `busy` is 1 is ignored and sets no other draining bit, so at most one bit of `flush_map` is ever 1.
- R3: A lookup (`acc_valid`, with `acc_way` equal to the draining way) on an unfinished set is handled as follows. If `acc_dirty` is 1 and no writeback is outstanding, a writeback of that set is requested in the next cycle. If `acc_dirty` is 0, the set is recorded as finished with no writeback.
- R4: The walker starts at set 0 and moves up through the set indices one step per cycle, wrapping at the end. It skips sets already finished. It probes unfinished sets through `probe_set`/`probe_dirty`, where `probe_dirty`=1 means modified. With no lookups, writebacks therefore complete in ascending set order.
- R5: At most one writeback is outstanding. `wb_req` stays 1, with `wb_way`/`wb_set` stable, until the cycle in which `wb_ack` is 1.
- R6: In a cycle where a lookup-triggered flush and the walker both want to act, the lookup wins: the next writeback is for `acc_set`.
- R7: During one contraction each set is written back at most once, and every set that was modified is written back before completion. A clean set is never written back.
- R8: When all sets are finished and no writeback is outstanding, the permission bit and the draining bit are cleared on the same edge at which `done` rises. `done` lasts one cycle and `busy` is 0 with it.
- R9: The permission bit of core c for way w is `perm_map[w*NUM_CORES + c]`. A completed contraction changes only that bit of `perm_map`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to contract one core's share by one way |
| start_way | input | log2(NUM_WAYS) | Way to drain |
| start_core | input | log2(NUM_CORES) | Core losing the way |
| busy | output | 1 | A contraction is in progress; requests refused |
| done | output | 1 | One-cycle completion pulse |
| acc_valid | input | 1 | A core lookup occurs this cycle |
| acc_way | input | log2(NUM_WAYS) | Way the lookup targets |
| acc_set | input | log2(NUM_SETS) | Set index of the lookup |
| acc_dirty | input | 1 | Looked-up line is modified |
| probe_set | output | log2(NUM_SETS) | Set the walker is examining |
| probe_dirty | input | 1 | Line at (draining way, probe_set) is modified |
| wb_req | output | 1 | Writeback request, held until acknowledged |
| wb_way | output | log2(NUM_WAYS) | Way of the line to write back |
| wb_set | output | log2(NUM_SETS) | Set of the line to write back |
| wb_ack | input | 1 | Memory side accepted the writeback |
| perm_map | output | NUM_WAYS*NUM_CORES | Per-way, per-core access permission bits |
| flush_map | output | NUM_WAYS | Per-way draining bits |

## Verification
The assertions rely on a few things about the inputs. `wb_ack` is only raised while `wb_req` is 1. `probe_dirty` and `acc_dirty` report the true state of the addressed line in the same cycle. A line, once written back, does not become dirty again while its way is draining. The bench enforces all of this by keeping a model of the dirty state of every way and set and deriving both dirty inputs from it. It clears a line's dirty bit only at the acknowledged handshake, and it raises `wb_ack` only while a request is visible. Lookups are random over all ways and sets, with a bias toward the draining way.

// File: rtl/wsc_pkg.sv
package wsc_pkg;

  // index width for a count of n items (at least one bit)
  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // next index in a wrapping ascending walk over n entries
  function automatic int wrap_next(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // flat position of the permission bit of core c for way w
  function automatic int perm_pos(input int w, input int c, input int ncores);
    return w * ncores + c;
  endfunction

endpackage

// File: rtl/wsc_contract_vec.sv
module wsc_contract_vec #(
  parameter int NUM_SETS = 16,
  localparam int SET_W = wsc_pkg::idx_w(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                mark_en,
  input  logic [SET_W-1:0]    mark_idx,
  output logic [NUM_SETS-1:0] marked,
  output logic                all_marked
);

  logic [NUM_SETS-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) vec_q <= '0;
    else if (mark_en) vec_q[mark_idx] <= 1'b1;
  end

  assign marked     = vec_q;
  assign all_marked = &vec_q;

  // a set is recorded only once per contraction
  AST_MARK_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |-> !vec_q[mark_idx]); // R7

endmodule

// File: rtl/wsc_sweeper.sv
module wsc_sweeper #(
  parameter int NUM_SETS = 16,
  localparam int SET_W = wsc_pkg::idx_w(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [SET_W-1:0] ptr
);

  logic [SET_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) ptr_q <= '0;
    else if (advance) ptr_q <= SET_W'(wsc_pkg::wrap_next(int'(ptr_q), NUM_SETS));
  end

  assign ptr = ptr_q;

  // pointer only moves upward by one or wraps to zero
  AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart) |=> (ptr_q == SET_W'(wsc_pkg::wrap_next(int'($past(ptr_q)), NUM_SETS)))); // R4

endmodule

// File: rtl/wsc_wb_port.sv
module wsc_wb_port #(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [SET_W-1:0] issue_set,
  input  logic             ack,
  output logic             wb_req,
  output logic [SET_W-1:0] wb_set,
  output logic             pending
);

  logic             busy_q;
  logic [SET_W-1:0] set_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      set_q  <= '0;
    end else if (issue) begin
      busy_q <= 1'b1;
      set_q  <= issue_set;
    end else if (ack) begin
      busy_q <= 1'b0;
    end
  end

  assign wb_req  = busy_q;
  assign wb_set  = set_q;
  assign pending = busy_q;

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !ack) |=> (wb_req && $stable(wb_set))); // R5
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !busy_q); // R5

endmodule

// File: rtl/wsc_perm_table.sv
module wsc_perm_table #(
  parameter int NUM_WAYS  = 8,
  parameter int NUM_CORES = 4,
  localparam int WAY_W  = wsc_pkg::idx_w(NUM_WAYS),
  localparam int CORE_W = wsc_pkg::idx_w(NUM_CORES),
  localparam int PERM_N = NUM_WAYS * NUM_CORES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_flush,
  input  logic [WAY_W-1:0]  set_way,
  input  logic              clr_en,
  input  logic [WAY_W-1:0]  clr_way,
  input  logic [CORE_W-1:0] clr_core,
  output logic [PERM_N-1:0] perm_map,
  output logic [NUM_WAYS-1:0] flush_map
);

  logic [PERM_N-1:0]   perm_q;
  logic [NUM_WAYS-1:0] flush_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perm_q  <= '1;
      flush_q <= '0;
    end else begin
      if (set_flush) flush_q[set_way] <= 1'b1;
      if (clr_en) begin
        flush_q[clr_way] <= 1'b0;
        perm_q[wsc_pkg::perm_pos(int'(clr_way), int'(clr_core), NUM_CORES)] <= 1'b0;
      end
    end
  end

  assign perm_map  = perm_q;
  assign flush_map = flush_q;

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flush_q)); // R2
  AST_SET_CLR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_flush && clr_en)); // R2
  AST_PERM_ONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ($countones($past(perm_q) ^ perm_q) <= 1)); // R9

endmodule

// File: rtl/wayshrink_ctrl.sv
module wayshrink_ctrl #(
  parameter int NUM_SETS  = 16,
  parameter int NUM_WAYS  = 8,
  parameter int NUM_CORES = 4,
  localparam int SET_W  = wsc_pkg::idx_w(NUM_SETS),
  localparam int WAY_W  = wsc_pkg::idx_w(NUM_WAYS),
  localparam int CORE_W = wsc_pkg::idx_w(NUM_CORES),
  localparam int PERM_N = NUM_WAYS * NUM_CORES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_valid,
  input  logic [WAY_W-1:0]    start_way,
  input  logic [CORE_W-1:0]   start_core,
  output logic                busy,
  output logic                done,
  input  logic                acc_valid,
  input  logic [WAY_W-1:0]    acc_way,
  input  logic [SET_W-1:0]    acc_set,
  input  logic                acc_dirty,
  output logic [SET_W-1:0]    probe_set,
  input  logic                probe_dirty,
  output logic                wb_req,
  output logic [WAY_W-1:0]    wb_way,
  output logic [SET_W-1:0]    wb_set,
  input  logic                wb_ack,
  output logic [PERM_N-1:0]   perm_map,
  output logic [NUM_WAYS-1:0] flush_map
);

  // contraction context
  logic              active_q;
  logic [WAY_W-1:0]  way_q;
  logic [CORE_W-1:0] core_q;
  logic              done_q;

  // named internal events
  logic                start_fire;
  logic                finish;
  logic                acc_hit, acc_new, acc_issue, acc_clean, acc_claim;
  logic                sweep_pending, sweep_skip, sweep_go, sweep_issue, sweep_clean;
  logic                mark_en, issue;
  logic [SET_W-1:0]    mark_idx, issue_set, ptr;
  logic [NUM_SETS-1:0] marked;
  logic                all_marked, wb_pending;

  assign start_fire = start_valid && !active_q;
  assign finish     = active_q && all_marked && !wb_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      way_q    <= '0;
      core_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_fire) begin
        active_q <= 1'b1;
        way_q    <= start_way;
        core_q   <= start_core;
      end else if (finish) begin
        active_q <= 1'b0;
      end
    end
  end

  // lookup-triggered flush
  assign acc_hit   = active_q && acc_valid && (acc_way == way_q);
  assign acc_new   = acc_hit && !marked[acc_set];
  assign acc_issue = acc_new && acc_dirty && !wb_pending;
  assign acc_clean = acc_new && !acc_dirty;
  assign acc_claim = acc_issue || acc_clean;

  // background walker, yields to any lookup action
  assign sweep_pending = active_q && !marked[ptr];
  assign sweep_skip    = active_q && marked[ptr] && !all_marked;
  assign sweep_go      = sweep_pending && !acc_claim && (!probe_dirty || !wb_pending);
  assign sweep_issue   = sweep_go && probe_dirty;
  assign sweep_clean   = sweep_go && !probe_dirty;

  assign mark_en   = acc_claim || sweep_go;
  assign mark_idx  = acc_claim ? acc_set : ptr;
  assign issue     = acc_issue || sweep_issue;
  assign issue_set = acc_issue ? acc_set : ptr;

  wsc_contract_vec #(.NUM_SETS(NUM_SETS)) vec_i (
    .clk(clk), .rst_n(rst_n), .clr(finish),
    .mark_en(mark_en), .mark_idx(mark_idx),
    .marked(marked), .all_marked(all_marked)
  );

  wsc_sweeper #(.NUM_SETS(NUM_SETS)) sweep_i (
    .clk(clk), .rst_n(rst_n), .restart(start_fire),
    .advance(sweep_skip || sweep_go), .ptr(ptr)
  );

  wsc_wb_port #(.SET_W(SET_W)) wb_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_set(issue_set),
    .ack(wb_ack), .wb_req(wb_req), .wb_set(wb_set), .pending(wb_pending)
  );

  wsc_perm_table #(.NUM_WAYS(NUM_WAYS), .NUM_CORES(NUM_CORES)) perm_i (
    .clk(clk), .rst_n(rst_n),
    .set_flush(start_fire), .set_way(start_way),
    .clr_en(finish), .clr_way(way_q), .clr_core(core_q),
    .perm_map(perm_map), .flush_map(flush_map)
  );

  assign busy      = active_q;
  assign done      = done_q;
  assign probe_set = ptr;
  assign wb_way    = way_q;

  AST_BUSY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> flush_map[way_q]); // R2
  AST_START_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_valid) |=> $stable(way_q)); // R2
  AST_ACC_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_claim && sweep_go)); // R6
  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clean || sweep_clean) |=> !$rose(wb_req)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wb_req && !flush_map[way_q]
              && !perm_map[wsc_pkg::perm_pos(int'(way_q), int'(core_q), NUM_CORES)])); // R8

endmodule

// File: tb/wayshrink_ctrl_tb_top.sv
module wayshrink_ctrl_tb_top;

  localparam int NS = 16;
  localparam int NW = 8;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic [2:0] start_way = '0;
  logic [1:0] start_core = '0;
  logic busy, done;
  logic acc_valid = 1'b0;
  logic [2:0] acc_way = '0;
  logic [3:0] acc_set = '0;
  logic acc_dirty = 1'b0;
  logic [3:0] probe_set;
  logic probe_dirty;
  logic wb_req;
  logic [2:0] wb_way;
  logic [3:0] wb_set;
  logic wb_ack = 1'b0;
  logic [NW*NC-1:0] perm_map;
  logic [NW-1:0] flush_map;

  // bench cache state model
  logic [NS-1:0] dirty_m [NW];
  logic [2:0] cur_way = '0;
  logic [NW*NC-1:0] exp_perm;

  int total = 0, bad = 0, cyc = 0;
  int wb_log [64];
  int wb_n = 0;
  bit done_seen;
  bit prev_wait = 0;
  logic [3:0] prev_set = '0;
  logic prev_flush = 1'b0;

  assign probe_dirty = dirty_m[cur_way][probe_set];

  always #4 clk = ~clk;

  wayshrink_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_way(start_way),
    .start_core(start_core), .busy(busy), .done(done), .acc_valid(acc_valid),
    .acc_way(acc_way), .acc_set(acc_set), .acc_dirty(acc_dirty),
    .probe_set(probe_set), .probe_dirty(probe_dirty), .wb_req(wb_req),
    .wb_way(wb_way), .wb_set(wb_set), .wb_ack(wb_ack),
    .perm_map(perm_map), .flush_map(flush_map)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pop16(input logic [NS-1:0] v);
    int n = 0;
    for (int i = 0; i < NS; i++) n += int'(v[i]);
    return n;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one cycle: observe at negedge, then drive inputs for the next edge
  task automatic step(input bit acc_on, input int ack_pct);
    bit ack_n;
    @(negedge clk);
    if (prev_wait) check(wb_req && wb_set == prev_set, "R5 hold", int'(wb_set), int'(prev_set));
    if (done) begin
      done_seen = 1;
      check(prev_flush == 1'b1, "R8 flush before done", int'(prev_flush), 1);
    end
    prev_flush = flush_map[cur_way];
    ack_n = wb_req && (($urandom % 100) < ack_pct);
    if (ack_n) begin
      check(wb_way == cur_way, "R7 wb way", int'(wb_way), int'(cur_way));
      check(dirty_m[wb_way][wb_set] == 1'b1, "R7 writeback of clean/repeated set", int'(wb_set), -1);
      dirty_m[wb_way][wb_set] = 1'b0;
      if (wb_n < 64) wb_log[wb_n] = int'(wb_set);
      wb_n++;
    end
    prev_wait = wb_req && !ack_n;
    prev_set  = wb_set;
    wb_ack = ack_n;
    if (acc_on) begin
      acc_valid = 1'($urandom % 2);
      acc_way   = (($urandom % 2) == 0) ? cur_way : 3'($urandom % NW);
      acc_set   = 4'($urandom % NS);
      acc_dirty = dirty_m[acc_way][acc_set];
    end else begin
      acc_valid = 1'b0;
    end
  endtask

  task automatic begin_run(input logic [2:0] w, input logic [1:0] c, input logic [NS-1:0] d);
    @(negedge clk);
    dirty_m[w] = d;
    cur_way = w;
    wb_n = 0;
    done_seen = 0;
    start_valid = 1'b1;
    start_way = w;
    start_core = c;
    acc_valid = 1'b0;
    wb_ack = 1'b0;
    @(negedge clk);
    start_valid = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    check(flush_map == (8'd1 << w), "R2 flush bit set", int'(flush_map), int'(8'd1 << w));
    prev_flush = flush_map[w];
  endtask

  task automatic finish_run(input logic [2:0] w, input logic [1:0] c, input bit acc_on,
                            input int ack_pct, input logic [NS-1:0] d0);
    int guard = 0;
    while (!done_seen && guard < 3000) begin
      step(acc_on, ack_pct);
      guard++;
    end
    check(done_seen, "R8 completion reached", int'(done_seen), 1);
    check(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    check(flush_map[w] == 1'b0, "R8 flush cleared", int'(flush_map[w]), 0);
    check(perm_map[int'(w)*NC + int'(c)] == 1'b0, "R8 perm cleared", int'(perm_map[int'(w)*NC + int'(c)]), 0);
    exp_perm[int'(w)*NC + int'(c)] = 1'b0;
    check(perm_map == exp_perm, "R9 only target perm bit changed", int'(perm_map), int'(exp_perm));
    check(dirty_m[w] == '0, "R7 all dirty sets written back", int'(dirty_m[w]), 0);
    check(wb_n == pop16(d0), "R7 writeback count", wb_n, pop16(d0));
    step(0, 100);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  initial begin
    int seed;
    logic [NS-1:0] d;
    logic [2:0] w;
    logic [1:0] c;
    bit asc;
    seed = $urandom(32'd2024);
    for (int i = 0; i < NW; i++) dirty_m[i] = '0;
    exp_perm = '1;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && wb_req == 0, "R1 idle outputs", int'({busy, done, wb_req}), 0);
    check(perm_map == '1, "R1 perm all ones", int'(perm_map), -1);
    check(flush_map == '0, "R1 flush clear", int'(flush_map), 0);
    rst_n = 1'b1;

    // sweep-only run: ascending order, refusal while busy
    d = 16'h1028;
    begin_run(3'd2, 2'd1, d);
    @(negedge clk);
    start_valid = 1'b1; start_way = 3'd5; start_core = 2'd2;
    @(negedge clk);
    start_valid = 1'b0;
    check(flush_map[5] == 1'b0, "R2 request refused while busy", int'(flush_map[5]), 0);
    finish_run(3'd2, 2'd1, 0, 100, d);
    asc = 1;
    for (int i = 1; i < wb_n; i++) if (wb_log[i] <= wb_log[i-1]) asc = 0;
    check(asc, "R4 ascending sweep order", wb_n, 3);
    check(wb_log[0] == 3 && wb_log[2] == 12, "R4 first and last set", wb_log[0], 3);

    // priority of a lookup over the walker, and lookup-triggered writeback
    d = '1;
    begin_run(3'd4, 2'd0, d);
    acc_valid = 1'b1; acc_way = 3'd4; acc_set = 4'd9; acc_dirty = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    check(wb_req == 1'b1 && wb_set == 4'd9, "R6 lookup wins, R3 dirty lookup flushes", int'(wb_set), 9);
    check(wb_way == 3'd4, "R3 writeback way", int'(wb_way), 4);
    finish_run(3'd4, 2'd0, 1, 60, d);

    // clean way drained by lookups and walker: no writebacks
    d = '0;
    begin_run(3'd6, 2'd3, d);
    acc_valid = 1'b1; acc_way = 3'd6; acc_set = 4'd0; acc_dirty = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    check(wb_req == 1'b0, "R3 clean lookup no writeback", int'(wb_req), 0);
    finish_run(3'd6, 2'd3, 1, 100, d);

    // writeback held without acknowledge
    d = 16'h0001;
    begin_run(3'd1, 2'd2, d);
    repeat (20) step(0, 0);
    check(wb_req == 1'b1 && busy == 1'b1, "R5 request held, no completion", int'(wb_req), 1);
    finish_run(3'd1, 2'd2, 1, 100, d);

    // constrained random contractions
    for (int r = 0; r < 8; r++) begin
      w = 3'($urandom % NW);
      c = 2'($urandom % NC);
      d = 16'($urandom);
      begin_run(w, c, d);
      finish_run(w, c, 1, 25 + int'($urandom % 70), d);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule